// File: doc/BRIEF.md
# Reference Clock Switchover Controller

This block picks one of two reference clocks and passes it, without glitches, to a downstream consumer such as a PLL reference input. A free-running monitor clock runs a loss detector for each input, a filter for the user's switch request, and a small handover sequencer. The sequencer switches the gated output clock from one input to the other.

A static 2-bit mode input picks one of three policies. In automatic mode, a stall of the active input moves the selection to the other input. In manual mode, only a qualified user request moves it. The third mode is automatic switching that a held request can override. The selected input, a stall flag for each input and a one-cycle switch strobe are all visible at the ports.

Top module: `refclk_switchover`

## Requirements
- R1: When reset is released, `sel` is 0, `bad_a`, `bad_b` and `sw_pulse` are low, and `clk_out` carries `clk_a` once its enable is up.
- R2: `mode` encodes the policy: 2'b00 automatic, 2'b01 manual, 2'b10 automatic with manual override, 2'b11 manual. It is held constant while the block runs and changes only during reset.
- R3: Both inputs are watched all the time. `bad_a`/`bad_b` go high after `TIMEOUT` (default 8) monitor cycles with no level change seen on that input, and drop again once it toggles.
- R4: In automatic mode, if the selected input is flagged bad and the other is not, the selection moves to the other input.
- R5: Automatic switching never moves to a flagged input. With both inputs flagged, the selection is kept and both flags are high.
- R6: In manual mode, a stalled selected input never changes the selection.
- R7: A request counts only after `sw_req` has been high for 3 consecutive monitor cycles after the synchronizer. A shorter pulse is ignored, and one held request counts once.
- R8: Each qualified request in manual or override mode flips the selection (0 to 1, 1 to 0).
- R9: In automatic mode, `sw_req` has no effect on the selection.
- R10: In override mode, a held-high `sw_req` blocks every automatic switch. A qualified request still flips the selection, and automatic switching resumes once the request falls.
- R11: `sw_pulse` is high for exactly one monitor cycle, the same cycle in which `sel` takes its new value, and only then.
- R12: The two clock enables are never on together. After a handover, `clk_out` runs at the rate of the newly selected input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_a | input | 1 | Reference input 0 |
| clk_b | input | 1 | Reference input 1 |
| mode | input | 2 | Static switchover policy |
| sw_req | input | 1 | User switch request (asynchronous) |
| sel | output | 1 | Selected input (0 = clk_a, 1 = clk_b) |
| clk_out | output | 1 | Gated, glitch-free selected clock |
| bad_a | output | 1 | clk_a has stopped toggling |
| bad_b | output | 1 | clk_b has stopped toggling |
| sw_pulse | output | 1 | One-cycle strobe on each selection change |

## Verification
The bench sends a two-cycle request pulse. A filter that is too short would flip the selection on it. It also holds a request for many cycles, where a filter that re-arms while the request stays high would flip the selection more than once. It stops both inputs in automatic mode: a design that ignores the health of the target would jump onto a dead clock and `clk_out` would go flat. In override mode it stops the selected input while the request is still held, which catches a design that lets the loss detector act anyway. The output rate is measured after every handover to show that the gated clock really follows `sel`.

// File: rtl/refclk_switchover.sv
module refclk_switchover #(
  parameter int TIMEOUT = 8
) (
  input  logic       mon_clk,
  input  logic       rst_n,
  input  logic       clk_a,
  input  logic       clk_b,
  input  logic [1:0] mode,
  input  logic       sw_req,
  output logic       sel,
  output logic       clk_out,
  output logic       bad_a,
  output logic       bad_b,
  output logic       sw_pulse
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);
  localparam logic [1:0] M_AUTO = 2'b00, M_MAN = 2'b01, M_OVR = 2'b10;

  typedef enum logic {S_RUN, S_OFF} st_t;

  wire  [1:0] rclk = {clk_b, clk_a};
  logic [1:0] bad, req_en, kill_q, en_r, en_m;
  logic [1:0] req_m, rcnt;
  st_t        st;

  for (genvar i = 0; i < 2; i++) begin : g_ref
    logic [2:0]    smp;
    logic [CW-1:0] idle;
    logic [1:0]    en_p, ack_p;
    wire           kill = !rst_n || kill_q[i];

    always_ff @(posedge mon_clk or negedge rst_n)
      if (!rst_n) begin
        smp <= '0; idle <= '0; ack_p <= '0;
      end else begin
        smp   <= {smp[1:0], rclk[i]};
        ack_p <= {ack_p[0], en_p[1]};
        if (smp[2] != smp[1]) idle <= '0;
        else if (idle != LIMIT) idle <= idle + 1'b1;
      end

    always_ff @(negedge rclk[i] or posedge kill)
      if (kill) en_p <= '0;
      else      en_p <= {en_p[0], req_en[i]};

    assign bad[i]  = (idle == LIMIT);
    assign en_r[i] = en_p[1];
    assign en_m[i] = ack_p[1];
  end

  assign clk_out = |(rclk & en_r);
  assign bad_a   = bad[0];
  assign bad_b   = bad[1];

  wire req_s   = req_m[1];
  wire qual    = req_s && (rcnt == 2'd2);
  wire man_on  = (mode != M_AUTO);
  wire auto_on = (mode == M_AUTO) || (mode == M_OVR && !req_s);
  wire cur_bad = bad[sel];
  wire oth_bad = bad[!sel];
  wire ready   = en_m[sel] || cur_bad;
  wire trig    = ready && ((man_on && qual) || (auto_on && cur_bad && !oth_bad));

  always_ff @(posedge mon_clk or negedge rst_n)
    if (!rst_n) begin
      req_m <= '0; rcnt <= '0; st <= S_RUN; sel <= 1'b0;
      req_en <= 2'b01; kill_q <= '0; sw_pulse <= 1'b0;
    end else begin
      req_m    <= {req_m[0], sw_req};
      rcnt     <= !req_s ? 2'd0 : (rcnt == 2'd3 ? rcnt : rcnt + 2'd1);
      kill_q   <= bad & ~req_en;
      sw_pulse <= 1'b0;
      case (st)
        S_RUN: if (trig) begin
          req_en <= 2'b00;
          st     <= S_OFF;
        end
        S_OFF: if (!en_m[sel] || cur_bad) begin
          sel      <= !sel;
          req_en   <= sel ? 2'b01 : 2'b10;
          sw_pulse <= 1'b1;
          st       <= S_RUN;
        end
        default: st <= S_RUN;
      endcase
    end

  a_r11_change_has_pulse: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> sw_pulse);
  a_r11_pulse_has_change: assert property (@(posedge mon_clk) disable iff (!rst_n)
    sw_pulse |-> (sel != $past(sel)));
  a_r7_three_cycles: assert property (@(posedge mon_clk) disable iff (!rst_n)
    qual |-> (req_s && $past(req_s) && $past(req_s, 2)));
  a_r6_manual_no_auto: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (st == S_RUN && mode == M_MAN && !qual) |=> st == S_RUN);
  a_r10_override_holds: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (st == S_RUN && mode == M_OVR && req_s && !qual) |=> st == S_RUN);
  a_r12_one_enable: assert property (@(posedge mon_clk) disable iff (!rst_n)
    !(en_r[0] && en_r[1]));
endmodule

// File: tb/refclk_switchover_test.sv
`timescale 1ns/1ps
module refclk_switchover_test;
  logic mon_clk = 0, rst_n = 0, clk_a = 0, clk_b = 0, sw_req = 0;
  logic run_a = 1, run_b = 1;
  logic [1:0] mode = 2'b00;
  logic sel, clk_out, bad_a, bad_b, sw_pulse;
  int tests = 0, fails = 0, out_edges = 0;
  bit prev_pulse = 0, done = 0;
  logic exp_q[$];

  refclk_switchover uut (.mon_clk(mon_clk), .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b),
    .mode(mode), .sw_req(sw_req), .sel(sel), .clk_out(clk_out), .bad_a(bad_a),
    .bad_b(bad_b), .sw_pulse(sw_pulse));

  initial forever #2 mon_clk = ~mon_clk;
  initial forever begin #10; clk_a = run_a ? ~clk_a : 1'b0; end
  initial forever begin #12; clk_b = run_b ? ~clk_b : 1'b0; end
  always @(posedge clk_out) out_edges++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe pops one expected selection
  always @(negedge mon_clk) begin
    if (rst_n && sw_pulse) begin
      check(!prev_pulse, "R11 strobe longer than one cycle", 1, 0);
      if (exp_q.size() == 0) check(0, "R11 unexpected switch, sel", sel, -1);
      else begin
        automatic logic e = exp_q.pop_front();
        check(sel == e, "R8 switch target", sel, e);
      end
    end
    prev_pulse = rst_n && sw_pulse;
  end

  task automatic wait_mon(input int n);
    repeat (n) @(negedge mon_clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 0; mode = m; sw_req = 0; run_a = 1; run_b = 1;
    wait_mon(5);
    rst_n = 1;
    wait_mon(40);
  endtask

  task automatic pulse_req(input int n);
    @(negedge mon_clk) sw_req = 1;
    wait_mon(n);
    sw_req = 0;
  endtask

  task automatic rate_check(input int exp, input string tag);
    int e0 = out_edges;
    #480;
    check((out_edges - e0 >= exp - 1) && (out_edges - e0 <= exp + 1), tag, out_edges - e0, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #800000;
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    // R1 reset state (automatic mode)
    do_reset(2'b00);
    check(sel == 0, "R1 sel after reset", sel, 0);
    check(!bad_a && !bad_b, "R1 flags after reset", {bad_a, bad_b}, 0);
    check(!sw_pulse, "R1 strobe after reset", sw_pulse, 0);
    rate_check(24, "R1 R12 clk_out follows clk_a");

    // manual mode (R2 code 01)
    do_reset(2'b01);
    pulse_req(2); wait_mon(60);
    check(sel == 0, "R7 short pulse ignored", sel, 0);
    exp_q.push_back(1'b1);
    pulse_req(12); wait_mon(60);
    check(sel == 1, "R8 R2 manual flip to 1", sel, 1);
    rate_check(20, "R12 clk_out follows clk_b");
    exp_q.push_back(1'b0);
    pulse_req(40); wait_mon(60);
    check(sel == 0, "R7 long hold flips once", sel, 0);
    run_a = 0; wait_mon(60);
    check(bad_a == 1, "R3 loss flagged", bad_a, 1);
    check(sel == 0, "R6 manual ignores loss", sel, 0);
    run_a = 1; wait_mon(30);
    check(bad_a == 0, "R3 flag clears on toggling", bad_a, 0);

    // automatic mode
    do_reset(2'b00);
    pulse_req(12); wait_mon(60);
    check(sel == 0, "R9 request ignored in auto", sel, 0);
    run_b = 0; wait_mon(60);
    check(bad_b == 1 && sel == 0, "R3 idle input flagged, no switch", {bad_b, sel}, 2);
    run_a = 0; wait_mon(60);
    check(sel == 0, "R5 no switch onto bad input", sel, 0);
    check(bad_a && bad_b, "R5 both flags high", {bad_a, bad_b}, 3);
    exp_q.push_back(1'b1);
    run_b = 1; wait_mon(80);
    check(sel == 1, "R4 auto switch to healthy input", sel, 1);
    check(bad_a == 1, "R3 stopped input still flagged", bad_a, 1);
    rate_check(20, "R12 clk_out after auto handover");

    // automatic with override (R2 code 10)
    do_reset(2'b10);
    exp_q.push_back(1'b1);
    @(negedge mon_clk) sw_req = 1;
    wait_mon(60);
    check(sel == 1, "R10 qualified request flips", sel, 1);
    run_b = 0; wait_mon(60);
    check(bad_b == 1 && sel == 1, "R10 held request blocks auto", {bad_b, sel}, 3);
    exp_q.push_back(1'b0);
    sw_req = 0; wait_mon(80);
    check(sel == 0, "R10 auto resumes after release", sel, 0);
    rate_check(24, "R12 clk_out back on clk_a");

    check(exp_q.size() == 0, "R11 missing switch strobes", exp_q.size(), 0);
    finish_run();
  end
endmodule